// File: doc/BRIEF.md
# Packed Decimal Subtractor

This block subtracts one unsigned decimal number from another, both held as packed BCD with two digits per byte. It is meant for control paths that keep their quantities in decimal, such as working out where a frequency sweep begins by taking half the span away from the centre value, without ever converting to binary.

The difference is never formed with a decimal subtractor. Each byte of the minuend is first replaced by its nines complement (0x99 minus the byte). The subtrahend byte and the carry from the byte below are then added to it. A decimal adjust follows: 6 is added to a nibble whose sum went past 9, and the carry moves on to the next digit. Finally the adjusted byte is complemented once more. One byte is handled per clock, starting at the least significant end, and the decimal carry is kept in a register from one byte to the next. A carry out of the top byte means the subtrahend was larger. In that case the difference wraps to the tens complement.

The block also has a negate mode, which ignores the minuend and returns the tens complement of the subtrahend. Every operand nibble is checked against the decimal range, and a flag reports any nibble that is out of range.

Top module: `bcd_subtractor`

## Requirements
- R1: After reset, ready is 1 and done, borrow, bad_digit and every bit of diff_bcd are 0.
- R2: A start is taken only in a cycle where ready is 1. A start raised while ready is 0 changes neither the operation in progress nor its result.
- R3: If a start is taken at clock edge E, then ready is 0 from E until edge E+ceil(NDIG/2). At that edge done rises, ready returns to 1, and done stays high for exactly one cycle.
- R4: When the value of A is at least the value of B, diff_bcd is A minus B in packed BCD and borrow is 0. This holds even when decimal borrows ripple across several bytes.
- R5: When B is larger than A, borrow is 1 and diff_bcd is 10^NDIG minus (B minus A).
- R6: Equal operands give a diff_bcd of all zero digits and a borrow of 0.
- R7: In every operand and in the result, digit i sits in bits [4i+3:4i], and digit 0 is the least significant.
- R8: With negate set at the start, A is ignored. diff_bcd is then (10^NDIG minus B) mod 10^NDIG, and borrow is 1 exactly when B is nonzero.
- R9: bad_digit updates together with done. It is 1 when any nibble of B is above 9, or any nibble of A is above 9 and negate was 0. Otherwise it is 0.
- R10: diff_bcd, borrow and bad_digit keep their values from done until the next operation completes, whatever the operand inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new operation; taken only while ready is high |
| ready | output | 1 | Idle and able to take a start |
| negate | input | 1 | Ignore A and return the tens complement of B |
| a_bcd | input | 4*NDIG | Minuend A, packed BCD |
| b_bcd | input | 4*NDIG | Subtrahend B, packed BCD |
| diff_bcd | output | 4*NDIG | Difference, packed BCD, held |
| borrow | output | 1 | B was larger than A, held |
| bad_digit | output | 1 | An operand nibble was above 9, held |
| done | output | 1 | One-cycle pulse when the result is updated |

## Verification
A decimal carry register that holds a wrong value corrupts only the digits above the point of failure. Such a fault therefore shows up only with operands whose borrow travels across byte boundaries, such as 10000000 minus 1. When it does appear, it shows in diff_bcd and borrow on the very next done. A byte counter or state register that goes wrong moves the done pulse or the ready edge by at least one cycle. The reference model compares those two pins on every clock, so the fault is reported in the cycle where it first occurs.

// File: rtl/bcdsub_pkg.sv
package bcdsub_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sub_state_t;

  function automatic int bytes_for(input int ndig);
    return (ndig + 1) / 2;
  endfunction
endpackage

// File: rtl/bcd_nibble_check.sv
module bcd_nibble_check #(
  parameter int NDIG = 8
) (
  input  logic [4*NDIG-1:0] vec,
  output logic              any_bad
);
  logic [NDIG-1:0] flag;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign flag[g] = (vec[4*g +: 4] > 4'd9);
  end

  assign any_bad = |flag;
endmodule

// File: rtl/bcd_byte_step.sv
module bcd_byte_step (
  input  logic [7:0] a_byte,
  input  logic [7:0] b_byte,
  input  logic       cin,
  output logic [7:0] d_byte,
  output logic       cout
);
  logic [3:0] comp_lo, comp_hi;
  logic [4:0] sum_lo, sum_hi;
  logic       half;
  logic       full;
  logic [3:0] adj_lo, adj_hi;

  always_comb begin
    // nines complement of the minuend byte, nibble by nibble (0x99 - a)
    comp_lo = 4'd9 - a_byte[3:0];
    comp_hi = 4'd9 - a_byte[7:4];
    // low digit: binary sum, then +6 correction when it passes 9
    sum_lo  = {1'b0, comp_lo} + {1'b0, b_byte[3:0]} + {4'b0000, cin};
    half    = (sum_lo > 5'd9);
    adj_lo  = half ? (sum_lo[3:0] + 4'd6) : sum_lo[3:0];
    // high digit: the 0x60 correction and the carry to the next byte
    sum_hi  = {1'b0, comp_hi} + {1'b0, b_byte[7:4]} + {4'b0000, half};
    full    = (sum_hi > 5'd9);
    adj_hi  = full ? (sum_hi[3:0] + 4'd6) : sum_hi[3:0];
    // complement back to obtain this byte of A - B
    d_byte  = {4'd9 - adj_hi, 4'd9 - adj_lo};
    cout    = full;
  end
endmodule

// File: rtl/bcd_sub_ctrl.sv
module bcd_sub_ctrl
  import bcdsub_pkg::*;
#(
  parameter int NDIG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              negate,
  input  logic              bad_in,
  input  logic [4*NDIG-1:0] a_bcd,
  input  logic [4*NDIG-1:0] b_bcd,
  output logic              ready,
  output logic              done,
  output logic [4*NDIG-1:0] diff_bcd,
  output logic              borrow,
  output logic              bad_digit
);
  localparam int DW = 4 * NDIG;
  localparam int NB = bytes_for(NDIG);
  localparam int PW = NB * BYTE_W;
  localparam int CW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [CW-1:0] LAST = CW'(NB - 1);

  sub_state_t  state;
  logic [CW-1:0] cnt;
  logic [PW-1:0] a_sh, b_sh, r_sh, r_next;
  logic          carry_q;
  logic          bad_pend;
  logic [7:0]    d_byte;
  logic          cout;
  logic          accept;
  logic          last;

  assign accept = (state == ST_IDLE) && start;
  assign last   = (state == ST_RUN) && (cnt == LAST);
  assign ready  = (state == ST_IDLE);

  bcd_byte_step u_step (
    .a_byte (a_sh[7:0]),
    .b_byte (b_sh[7:0]),
    .cin    (carry_q),
    .d_byte (d_byte),
    .cout   (cout)
  );

  if (NB == 1) begin : g_one
    assign r_next = d_byte;
  end else begin : g_many
    assign r_next = {d_byte, r_sh[PW-1:BYTE_W]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      a_sh      <= '0;
      b_sh      <= '0;
      r_sh      <= '0;
      carry_q   <= 1'b0;
      bad_pend  <= 1'b0;
      done      <= 1'b0;
      diff_bcd  <= '0;
      borrow    <= 1'b0;
      bad_digit <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        a_sh     <= negate ? '0 : PW'(a_bcd);
        b_sh     <= PW'(b_bcd);
        carry_q  <= 1'b0;
        cnt      <= '0;
        bad_pend <= bad_in;
        state    <= ST_RUN;
      end else if (state == ST_RUN) begin
        r_sh    <= r_next;
        a_sh    <= a_sh >> BYTE_W;
        b_sh    <= b_sh >> BYTE_W;
        carry_q <= cout;
        cnt     <= cnt + CW'(1);
        if (last) begin
          state     <= ST_IDLE;
          done      <= 1'b1;
          diff_bcd  <= r_next[DW-1:0];
          borrow    <= cout;
          bad_digit <= bad_pend;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready); // R3
  AST_RUN_NOT_RESTARTED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && cnt != LAST) |=> (state == ST_RUN && cnt == $past(cnt) + CW'(1))); // R2
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start) |=> ($stable(diff_bcd) && $stable(borrow) && $stable(bad_digit))); // R10
  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !bad_pend) |-> (d_byte[3:0] <= 4'd9 && d_byte[7:4] <= 4'd9)); // R4
endmodule

// File: rtl/bcd_subtractor.sv
module bcd_subtractor #(
  parameter int NDIG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ready,
  input  logic              negate,
  input  logic [4*NDIG-1:0] a_bcd,
  input  logic [4*NDIG-1:0] b_bcd,
  output logic [4*NDIG-1:0] diff_bcd,
  output logic              borrow,
  output logic              bad_digit,
  output logic              done
);
  logic a_bad, b_bad, bad_in;

  bcd_nibble_check #(.NDIG(NDIG)) u_chk_a (.vec(a_bcd), .any_bad(a_bad));
  bcd_nibble_check #(.NDIG(NDIG)) u_chk_b (.vec(b_bcd), .any_bad(b_bad));

  // the minuend is not consulted in negate mode, so it cannot flag
  assign bad_in = b_bad | (a_bad & ~negate);

  bcd_sub_ctrl #(.NDIG(NDIG)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .negate    (negate),
    .bad_in    (bad_in),
    .a_bcd     (a_bcd),
    .b_bcd     (b_bcd),
    .ready     (ready),
    .done      (done),
    .diff_bcd  (diff_bcd),
    .borrow    (borrow),
    .bad_digit (bad_digit)
  );

  AST_BORROW_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $past(rst_n)) |-> ($stable(borrow) || done)); // R10
endmodule

// File: tb/test_bcd_subtractor.sv
module test_bcd_subtractor;
  localparam int NDIG = 8;
  localparam int NB   = (NDIG + 1) / 2;
  localparam int DW   = 4 * NDIG;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, negate = 1'b0;
  logic [DW-1:0] a_bcd = '0, b_bcd = '0;
  logic ready, done, borrow, bad_digit;
  logic [DW-1:0] diff_bcd;

  always #2 clk = ~clk;

  bcd_subtractor #(.NDIG(NDIG)) i_bcd_subtractor (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .negate(negate),
    .a_bcd(a_bcd), .b_bcd(b_bcd), .diff_bcd(diff_bcd), .borrow(borrow),
    .bad_digit(bad_digit), .done(done)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";

  function automatic longint to_int(input logic [DW-1:0] v);
    longint r = 0;
    for (int i = NDIG - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [DW-1:0] to_bcd(input longint x);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < NDIG; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic bit has_bad(input logic [DW-1:0] v);
    for (int i = 0; i < NDIG; i++) if (v[4*i +: 4] > 4'd9) return 1'b1;
    return 1'b0;
  endfunction

  function automatic longint modulus();
    longint m = 1;
    for (int i = 0; i < NDIG; i++) m = m * 10;
    return m;
  endfunction

  // reference model, advanced on each rising edge
  bit m_ready, m_done, m_borrow, m_bad, p_borrow, p_bad;
  logic [DW-1:0] m_diff, p_diff;
  int busy_left;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready = 1; m_done = 0; m_diff = '0; m_borrow = 0; m_bad = 0; busy_left = 0;
    end else begin
      m_done = 0;
      if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0) begin
          m_ready = 1; m_done = 1; m_diff = p_diff; m_borrow = p_borrow; m_bad = p_bad;
        end
      end else if (start) begin
        longint av, bv, dv;
        av = negate ? 0 : to_int(a_bcd);
        bv = to_int(b_bcd);
        p_borrow = (bv > av);
        dv = av - bv;
        if (dv < 0) dv = dv + modulus();
        p_diff = to_bcd(dv);
        p_bad = has_bad(b_bcd) || (!negate && has_bad(a_bcd));
        busy_left = NB;
        m_ready = 0;
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("ready", 64'(ready), 64'(m_ready));
      chk("done", 64'(done), 64'(m_done));
      chk("bad_digit", 64'(bad_digit), 64'(m_bad));
      if (!m_bad) begin
        chk("diff", 64'(diff_bcd), 64'(m_diff));
        chk("borrow", 64'(borrow), 64'(m_borrow));
      end
    end
  end

  task automatic run_op(input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input bit neg, input string req);
    while (!ready) @(negedge clk);
    cur_req = req;
    a_bcd = a; b_bcd = b; negate = neg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    cur_req = "R1";
    repeat (2) @(negedge clk);

    run_op(32'h12345678, 32'h01234567, 0, "R7");
    run_op(32'h10000000, 32'h00000001, 0, "R4");
    run_op(32'h00500000, 32'h00000999, 0, "R4");
    run_op(32'h00000001, 32'h00000002, 0, "R5");
    run_op(32'h00000000, 32'h99999999, 0, "R5");
    run_op(32'h99999999, 32'h99999999, 0, "R6");
    run_op(32'h00000000, 32'h00000000, 0, "R6");
    run_op(32'h55555555, 32'h00000001, 1, "R8");
    run_op(32'h87654321, 32'h00000000, 1, "R8");
    run_op(32'h0000000A, 32'h00000003, 0, "R9");
    run_op(32'h00000003, 32'h00F00000, 0, "R9");
    run_op(32'hFFFFFFFF, 32'h00000042, 1, "R9");

    // operands change while idle: results must hold
    cur_req = "R10";
    a_bcd = 32'h31415926; b_bcd = 32'h27182818; negate = 1'b0;
    repeat (5) @(negedge clk);

    // start held high while busy: must be ignored
    while (!ready) @(negedge clk);
    cur_req = "R2";
    a_bcd = 32'h00002000; b_bcd = 32'h00000001; start = 1'b1;
    @(negedge clk);
    a_bcd = 32'h00000000; b_bcd = 32'h99999999;
    repeat (NB - 1) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);

    // back-to-back: start in the cycle after done
    cur_req = "R3";
    run_op(32'h00010000, 32'h00000001, 0, "R3");
    run_op(32'h00000010, 32'h00000011, 0, "R3");

    for (int k = 0; k < 40; k++) begin
      logic [DW-1:0] ra, rb;
      bit ng;
      for (int i = 0; i < NDIG; i++) begin
        ra[4*i +: 4] = 4'($urandom_range(9));
        rb[4*i +: 4] = 4'($urandom_range(9));
      end
      ng = (k % 5 == 0);
      if (ng) run_op(ra, rb, 1, "R8");
      else if (to_int(rb) > to_int(ra)) run_op(ra, rb, 0, "R5");
      else run_op(ra, rb, 0, "R4");
    end

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule